// File: doc/BRIEF.md
# Scrolling LCD Scan Line Generator

This block is the display-side timing core of a dot-matrix LCD controller. A line clock pulse moves it from one common line to the next. For each line it presents the scan index of the common being driven and the display RAM row to fetch for that line. A scroll offset, captured once per frame, is added to the row sequence, so the picture can scroll or switch pages without rewriting the RAM. The core also produces the frame-inversion signal and encodes the drive level for one observed common output and one segment output.

Two strap inputs set the frame length: half the graphic rows plus one, three quarters plus one, or all graphic rows plus one icon line. The icon line is fetched from a fixed RAM row that the scroll offset never moves.

A two-state machine tracks where the scan is. ST_GRAPHIC covers every line whose RAM row follows the scroll counter. ST_ICON covers the single icon line. The machine takes transition GRAPHIC_TO_ICON on the line tick at the last graphic row when the full duty is selected. It takes ICON_TO_GRAPHIC on the next line tick, which also starts a new frame. For the shorter duties, transition GRAPHIC_WRAP keeps the machine in ST_GRAPHIC at the frame boundary.

Top module: `scroll_scan_gen`

## Requirements
- R1: A one-cycle pulse on `start_wr` stores `start_val` as the scroll offset. The new offset has no effect on `row_addr` until the next frame begins.
- R2: When a frame begins (`scan_idx` returns to 0), the row counter takes the stored offset. Each later line tick adds one to it, modulo 64. On graphic lines `row_addr` equals the counter, with bit 6 clear.
- R3: With `duty_sel[1]`=1, scan index 64 is the icon line and `row_addr` is 64 whatever the offset. A frame begins on the following tick.
- R4: The number of lines per frame is 33 for `duty_sel`=00, 49 for 01, and 65 for 10 or 11. `scan_idx` counts from 0 up to that count minus one, then returns to 0.
- R5: `frame_m` inverts on exactly the ticks where `scan_idx` returns to 0, and holds on every other cycle.
- R6: The common level is 0 (VSS) for selected with M=1, 1 (V0) for selected with M=0, 2 (V1) for unselected with M=1, and 5 (V4) for unselected with M=0. "Selected" means `watch_com` equals `scan_idx`.
- R7: With `reverse_en`=0, the segment level is 1 (V0) for data 1 with M=1, 0 (VSS) for data 1 with M=0, 3 (V2) for data 0 with M=1, and 4 (V3) for data 0 with M=0.
- R8: With `reverse_en`=1, the segment level is the R7 level for the inverted `seg_bit`.
- R9: With `power_save`=1, both `com_level` and `seg_level` are 0 (VSS).
- R10: After reset, `scan_idx`, `row_addr`, `frame_m` and the stored offset are all 0.
- R11: On cycles without `line_tick`, `scan_idx`, `row_addr` and `frame_m` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_tick | input | 1 | One-cycle line clock pulse; advances the scan |
| start_wr | input | 1 | Strobe that stores `start_val` as the scroll offset |
| start_val | input | 6 | Scroll offset value |
| duty_sel | input | 2 | Duty straps: 00 = 33 lines, 01 = 49 lines, 1x = 65 lines |
| reverse_en | input | 1 | Inverts the sense of segment data |
| power_save | input | 1 | Forces every level to VSS |
| watch_com | input | 7 | Index of the observed common output |
| seg_bit | input | 1 | Display data bit for the observed segment |
| row_addr | output | 7 | RAM row to fetch for the current line (64 = icon row) |
| scan_idx | output | 7 | Index of the common line being scanned |
| frame_m | output | 1 | Frame-inversion signal |
| com_level | output | 3 | Level code for the observed common output |
| seg_level | output | 3 | Level code for the observed segment output |

## Verification
The bench builds the block with its default row-address width of 6. That gives 64 graphic rows and a 65-line frame, so every duty setting wraps within a few dozen line ticks. The settings chosen make the counter roll over from 63 to 0 inside a frame, and they bring in the icon slot at index 64. Level encoding is swept over both frame polarities, and so is the selected/unselected comparison with the live scan index.

// File: rtl/scroll_scan_pkg.sv
`timescale 1ns/1ps
package scroll_scan_pkg;

    typedef enum logic [0:0] {
        ST_GRAPHIC = 1'b0,
        ST_ICON    = 1'b1
    } scan_state_e;

    typedef enum logic [2:0] {
        LV_VSS = 3'd0,
        LV_V0  = 3'd1,
        LV_V1  = 3'd2,
        LV_V2  = 3'd3,
        LV_V3  = 3'd4,
        LV_V4  = 3'd5
    } drive_level_e;

    // Lines per frame for a duty strap setting, given the graphic row count.
    function automatic int unsigned frame_lines(input logic [1:0] sel,
                                                input int unsigned rows);
        if (sel[1])
            return rows + 1;
        else if (sel[0])
            return (rows * 3) / 4 + 1;
        else
            return rows / 2 + 1;
    endfunction

endpackage

// File: rtl/scroll_scan_start.sv
`timescale 1ns/1ps
module scroll_scan_start #(
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic [ROW_W-1:0] start_val,
    output logic [ROW_W-1:0] start_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            start_q <= '0;
        else if (start_wr)
            start_q <= start_val;
    end

    // R1: the offset changes only on a write strobe
    p_start_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !start_wr |=> $stable(start_q));

endmodule

// File: rtl/scroll_scan_seq.sv
`timescale 1ns/1ps
module scroll_scan_seq
    import scroll_scan_pkg::*;
#(
    parameter int ROW_W = 6,
    localparam int IDX_W    = ROW_W + 1,
    localparam int GFX_ROWS = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic [1:0]       duty_sel,
    input  logic [ROW_W-1:0] start_q,
    output logic [IDX_W-1:0] line_idx,
    output logic [ROW_W-1:0] row_ctr,
    output logic             frame_m,
    output logic             icon_active
);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] last_idx;
    logic             frame_end;
    logic             enter_icon;

    always_comb begin
        last_idx   = IDX_W'(frame_lines(duty_sel, GFX_ROWS) - 1);
        frame_end  = line_tick && (line_idx >= last_idx);
        enter_icon = line_tick && !frame_end && duty_sel[1]
                     && (line_idx == IDX_W'(GFX_ROWS - 1));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GRAPHIC: if (enter_icon) state_d = ST_ICON;    // GRAPHIC_TO_ICON
            ST_ICON:    if (frame_end)  state_d = ST_GRAPHIC; // ICON_TO_GRAPHIC
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_GRAPHIC;
        else
            state_q <= state_d;
    end

    // Scan counters and frame polarity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_idx <= '0;
            row_ctr  <= '0;
            frame_m  <= 1'b0;
        end else if (frame_end) begin
            line_idx <= '0;
            row_ctr  <= start_q;
            frame_m  <= ~frame_m;
        end else if (line_tick) begin
            line_idx <= line_idx + 1'b1;
            row_ctr  <= row_ctr + 1'b1;
        end
    end

    assign icon_active = (state_q == ST_ICON);

    // R2: inside a frame the row counter steps by one, modulo the graphic rows
    p_row_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !frame_end) |=> (row_ctr == $past(row_ctr) + 1'b1));

    // R2: a new frame loads the stored offset and restarts the index
    p_frame_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (row_ctr == $past(start_q)) && (line_idx == '0));

    // R4: the scan index never passes the icon slot
    p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_idx <= IDX_W'(GFX_ROWS));

    // R5: polarity flips at the frame boundary and nowhere else
    p_m_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (frame_m != $past(frame_m)));
    p_m_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(frame_m));

    // R11: no line tick, no movement
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(line_idx) && $stable(row_ctr));

endmodule

// File: rtl/scroll_scan_levels.sv
`timescale 1ns/1ps
module scroll_scan_levels
    import scroll_scan_pkg::*;
(
    input  logic       frame_m,
    input  logic       com_sel,
    input  logic       seg_bit,
    input  logic       reverse_en,
    input  logic       power_save,
    output logic [2:0] com_level,
    output logic [2:0] seg_level
);

    drive_level_e com_lv, seg_lv;
    logic         seg_on;

    always_comb begin
        seg_on = seg_bit ^ reverse_en;
        if (power_save) begin
            com_lv = LV_VSS;
            seg_lv = LV_VSS;
        end else begin
            unique case ({com_sel, frame_m})
                2'b11:   com_lv = LV_VSS;
                2'b10:   com_lv = LV_V0;
                2'b01:   com_lv = LV_V1;
                default: com_lv = LV_V4;
            endcase
            unique case ({seg_on, frame_m})
                2'b11:   seg_lv = LV_V0;
                2'b10:   seg_lv = LV_VSS;
                2'b01:   seg_lv = LV_V2;
                default: seg_lv = LV_V3;
            endcase
        end
    end

    assign com_level = com_lv;
    assign seg_level = seg_lv;

endmodule

// File: rtl/scroll_scan_gen.sv
`timescale 1ns/1ps
module scroll_scan_gen #(
    parameter int ROW_W = 6,
    localparam int IDX_W    = ROW_W + 1,
    localparam int GFX_ROWS = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic             start_wr,
    input  logic [ROW_W-1:0] start_val,
    input  logic [1:0]       duty_sel,
    input  logic             reverse_en,
    input  logic             power_save,
    input  logic [IDX_W-1:0] watch_com,
    input  logic             seg_bit,
    output logic [IDX_W-1:0] row_addr,
    output logic [IDX_W-1:0] scan_idx,
    output logic             frame_m,
    output logic [2:0]       com_level,
    output logic [2:0]       seg_level
);

    logic [ROW_W-1:0] start_q;
    logic [ROW_W-1:0] row_ctr;
    logic             icon_active;

    scroll_scan_start #(.ROW_W(ROW_W)) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .start_val (start_val),
        .start_q   (start_q)
    );

    scroll_scan_seq #(.ROW_W(ROW_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_tick   (line_tick),
        .duty_sel    (duty_sel),
        .start_q     (start_q),
        .line_idx    (scan_idx),
        .row_ctr     (row_ctr),
        .frame_m     (frame_m),
        .icon_active (icon_active)
    );

    // The icon row sits above the graphic rows and ignores the scroll counter
    assign row_addr = icon_active ? IDX_W'(GFX_ROWS) : {1'b0, row_ctr};

    scroll_scan_levels u_levels (
        .frame_m    (frame_m),
        .com_sel    (watch_com == scan_idx),
        .seg_bit    (seg_bit),
        .reverse_en (reverse_en),
        .power_save (power_save),
        .com_level  (com_level),
        .seg_level  (seg_level)
    );

    // R3: the icon slot always fetches the fixed icon row
    p_icon_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_idx == IDX_W'(GFX_ROWS)) |-> (row_addr == IDX_W'(GFX_ROWS)));

    // R6: a common output never takes a segment-only level
    p_com_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (com_level != 3'd3) && (com_level != 3'd4));

    // R9: power save parks every output on VSS
    p_save_vss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        power_save |-> (com_level == 3'd0) && (seg_level == 3'd0));

endmodule

// File: tb/scroll_scan_gen_bench.sv
`timescale 1ns/1ps
module scroll_scan_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0;
    logic       start_wr = 1'b0;
    logic [5:0] start_val = '0;
    logic [1:0] duty_sel = 2'b00;
    logic       reverse_en = 1'b0;
    logic       power_save = 1'b0;
    logic [6:0] watch_com = '0;
    logic       seg_bit = 1'b0;
    logic [6:0] row_addr, scan_idx;
    logic       frame_m;
    logic [2:0] com_level, seg_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        int    row;
        int    idx;
        int    m;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    // Bench model state, from the requirements
    int m_idx = 0, m_row = 0, m_start = 0, m_m = 0;

    always #2.5 clk = ~clk;

    scroll_scan_gen u_scroll_scan_gen (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .start_wr(start_wr),
        .start_val(start_val), .duty_sel(duty_sel), .reverse_en(reverse_en),
        .power_save(power_save), .watch_com(watch_com), .seg_bit(seg_bit),
        .row_addr(row_addr), .scan_idx(scan_idx), .frame_m(frame_m),
        .com_level(com_level), .seg_level(seg_level)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lines_for(input logic [1:0] d);
        return d[1] ? 65 : (d[0] ? 49 : 33);
    endfunction

    function automatic int exp_row();
        return (m_idx == 64) ? 64 : m_row;
    endfunction

    // Monitor: compare queued expectations against the outputs
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "row_addr", int'(row_addr), e.row);
            check("R4", "scan_idx", int'(scan_idx), e.idx);
            check("R5", "frame_m", int'(frame_m), e.m);
        end
    end

    // Driver: one line tick, model update, push expectation
    task automatic tick(input string tag);
        exp_t e;
        @(negedge clk) line_tick = 1'b1;
        @(negedge clk) line_tick = 1'b0;
        if (m_idx >= lines_for(duty_sel) - 1) begin
            m_idx = 0;
            m_row = m_start;
            m_m   = m_m ^ 1;
        end else begin
            m_idx = m_idx + 1;
            m_row = (m_row + 1) % 64;
        end
        e.row = exp_row();
        e.idx = m_idx;
        e.m   = m_m;
        e.tag = (m_idx == 64) ? "R3" : tag;
        sb_q.push_back(e);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic write_start(input int v);
        @(negedge clk);
        start_wr  = 1'b1;
        start_val = 6'(v);
        @(negedge clk);
        start_wr = 1'b0;
        m_start  = v;
    endtask

    task automatic align_frame();
        while (m_idx != 0) tick("R4");
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    // Sweep the level encoder at the present scan position and polarity
    task automatic level_sweep();
        for (int sel = 0; sel < 2; sel++)
            for (int d = 0; d < 2; d++)
                for (int rv = 0; rv < 2; rv++)
                    for (int ps = 0; ps < 2; ps++) begin
                        int ec, es, on;
                        watch_com  = sel ? 7'(m_idx) : 7'd100;
                        seg_bit    = d[0];
                        reverse_en = rv[0];
                        power_save = ps[0];
                        #1;
                        on = d ^ rv;
                        if (ps) begin
                            ec = 0; es = 0;
                        end else begin
                            ec = sel ? (m_m ? 0 : 1) : (m_m ? 2 : 5);
                            es = on ? (m_m ? 1 : 0) : (m_m ? 3 : 4);
                        end
                        check(ps ? "R9" : "R6", "com_level", int'(com_level), ec);
                        check(ps ? "R9" : (rv ? "R8" : "R7"), "seg_level", int'(seg_level), es);
                    end
        reverse_en = 1'b0;
        power_save = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10", "scan_idx", int'(scan_idx), 0);
        check("R10", "row_addr", int'(row_addr), 0);
        check("R10", "frame_m", int'(frame_m), 0);
        level_sweep();

        // 33-line frames, offset written mid-frame (R1), then wrap (R2)
        duty_sel = 2'b00;
        ticks(20, "R2");
        write_start(10);
        ticks(12, "R1");
        ticks(30, "R2");
        drain();
        level_sweep();

        // R11: no ticks, nothing moves
        repeat (6) @(negedge clk);
        check("R11", "scan_idx", int'(scan_idx), m_idx);
        check("R11", "row_addr", int'(row_addr), exp_row());
        check("R11", "frame_m", int'(frame_m), m_m);

        // 49-line frames with an offset that rolls over 63
        align_frame();
        duty_sel = 2'b01;
        write_start(50);
        ticks(110, "R2");

        // 65-line frames with icon slot, offset 60
        align_frame();
        duty_sel = 2'b11;
        write_start(60);
        ticks(64, "R2");
        drain();
        level_sweep();
        ticks(70, "R2");

        // duty 10 behaves as the full duty; zero offset
        align_frame();
        duty_sel = 2'b10;
        write_start(0);
        ticks(140, "R4");
        drain();
        level_sweep();

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule